// File: doc/BRIEF.md
# Interrupt Mitigation Delay Controller

This block sits between a network controller's interrupt cause and mask vectors and its single interrupt line. It turns the masked cause set into a line level. It also limits how often that line can rise. When the line rises with no quiet period running, the block works out a hold-off length from three programmable delays and starts one shared countdown. Any further rising edge that arrives during the countdown is held back. When the countdown ends, the block checks the pending set again. If causes are still pending, the line rises then and a new hold-off may start.

Software programs four 16-bit delay values through a simple write/read port:
- a receive gating value,
- a receive absolute delay,
- a transmit absolute delay,
- a throttle interval.

The transmit datapath pulses a strobe for each descriptor it consumes, together with that descriptor's delay-enable bit. A free-running tick, nominally one per nanosecond, drives the countdown. The chosen delay counts in units of 256 ticks.

Top module: `irq_moderator`

## Requirements
- R1: The pending set is the bitwise AND of `irq_mask` and `irq_cause`. A cause whose mask bit is clear never raises `irq_line`.
- R2: With no hold-off running, `irq_line` rises on the first clock edge after the pending set becomes nonzero. It falls on the first edge after the pending set becomes zero.
- R3: While a hold-off is running, a new rising edge is suppressed and `irq_line` stays low. A hold-off of D units lasts D×256 ticks. If causes are still pending when it ends, `irq_line` rises on the next clock edge.
- R4: The hold-off length is the smallest nonzero candidate, and a candidate of zero counts as unset. If every candidate is zero, no hold-off starts and edges pass straight through.
- R5: The transmit candidate is the transmit absolute delay (address 2) times 4. It counts only when the delay-enable flag is set and the pending set includes cause bit 0 (descriptor written) or bit 1 (transmit queue empty).
- R6: The receive candidate is the receive absolute delay (address 1) times 4. It counts only when the receive gating value (address 0) is nonzero and the pending set includes cause bit 7 (receive timer).
- R7: The throttle interval (address 3) is always a candidate, taken as is in 256-tick units.
- R8: A descriptor strobe with its delay-enable bit set sets a sticky flag. Each hold-off computation clears the flag, whether or not a hold-off starts.
- R9: With `mit_enable` low, no hold-off ever starts and `irq_line` follows the pending set one edge later.
- R10: The four delay values are 16-bit registers at addresses 0 to 3. Each reads back what was last written to it, and reset sets all four to zero.
- R11: Reset cancels any running hold-off and clears the line level and the delay-enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mit_enable | input | 1 | Enables hold-off computation |
| ns_tick | input | 1 | Time-base tick, one per nanosecond |
| irq_cause | input | CAUSE_W | Interrupt cause vector |
| irq_mask | input | CAUSE_W | Interrupt mask vector |
| dly_wr | input | 1 | Delay register write strobe |
| dly_addr | input | 2 | Delay register address (0 rx gate, 1 rx abs, 2 tx abs, 3 throttle) |
| dly_wdata | input | 16 | Delay register write data |
| dly_rdata | output | 16 | Delay register read data for `dly_addr` |
| txd_strobe | input | 1 | One pulse per transmit descriptor consumed |
| txd_dly_en | input | 1 | Delay-enable bit of that descriptor |
| irq_line | output | 1 | Interrupt line level |

## Verification
Three kinds of wrong internal state show up at the ports in distinct ways.

- **Stuck or miscounting hold-off timer.** The suppressed rise comes out early, late, or never. The error shows on the cycle the countdown should have ended, which is hundreds to thousands of cycles after the first rise, so the bench times every rise to the exact cycle.
- **Wrong candidate selection or a delay-enable flag left set.** The second rise lands at the wrong multiple of 256 cycles, or an edge that should pass straight through is delayed.
- **Wrong level tracking.** It shows within one cycle as a missing rise or a rise that was never expected.

// File: rtl/irqmod_pkg.sv
package irqmod_pkg;

  localparam int DLY_W = 16;

  typedef enum logic [1:0] {
    SEL_RX_GATE  = 2'd0,
    SEL_RX_ABS   = 2'd1,
    SEL_TX_ABS   = 2'd2,
    SEL_THROTTLE = 2'd3
  } dly_sel_e;

  typedef struct packed {
    logic [DLY_W-1:0] rx_gate;
    logic [DLY_W-1:0] rx_abs;
    logic [DLY_W-1:0] tx_abs;
    logic [DLY_W-1:0] thr;
  } dly_regs_t;

endpackage

// File: rtl/irqmod_rst_sync.sv
module irqmod_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  // assert asynchronously, release after STAGES clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/irqmod_regs.sv
module irqmod_regs
  import irqmod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [DLY_W-1:0] wdata,
  output logic [DLY_W-1:0] rdata,
  output dly_regs_t        regs
);

  localparam int NREG = 4;

  logic [DLY_W-1:0] q   [NREG];
  logic [DLY_W-1:0] d   [NREG];
  logic [NREG-1:0]  wen;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      wen[i] = wr && (addr == i[1:0]);
      d[i]   = wen[i] ? wdata : q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) q[i] <= d[i];
    end
  end

  assign rdata        = q[addr];
  assign regs.rx_gate = q[SEL_RX_GATE];
  assign regs.rx_abs  = q[SEL_RX_ABS];
  assign regs.tx_abs  = q[SEL_TX_ABS];
  assign regs.thr     = q[SEL_THROTTLE];

  // R10: a write lands in the addressed register
  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> q[$past(addr)] == $past(wdata));

endmodule

// File: rtl/irqmod_delay_sel.sv
module irqmod_delay_sel
  import irqmod_pkg::*;
#(
  parameter int CAUSE_W   = 16,
  parameter int TXDW_BIT  = 0,
  parameter int TXQE_BIT  = 1,
  parameter int RXT_BIT   = 7,
  parameter int ABS_SHIFT = 2,
  parameter int OUT_W     = DLY_W + ABS_SHIFT
) (
  input  logic [CAUSE_W-1:0] pending,
  input  logic               ide_flag,
  input  dly_regs_t          regs,
  output logic [OUT_W-1:0]   delay
);

  localparam int NCAND = 3;

  logic             tx_hit;
  logic             rx_hit;
  logic [OUT_W-1:0] cand [NCAND];
  logic [OUT_W-1:0] best;

  always_comb begin
    tx_hit  = ide_flag && (pending[TXDW_BIT] || pending[TXQE_BIT]);
    rx_hit  = (regs.rx_gate != '0) && pending[RXT_BIT];
    cand[0] = tx_hit ? (OUT_W'(regs.tx_abs) << ABS_SHIFT) : '0;
    cand[1] = rx_hit ? (OUT_W'(regs.rx_abs) << ABS_SHIFT) : '0;
    cand[2] = OUT_W'(regs.thr);
    best    = '0;
    for (int i = 0; i < NCAND; i++) begin
      if (cand[i] != '0 && (best == '0 || cand[i] < best)) best = cand[i];
    end
  end

  assign delay = best;

  // R7: throttle bounds the result from above whenever it is set
  always_comb begin
    if (regs.thr != '0) begin
      p_thr_bound_r7: assert (delay != '0 && delay <= OUT_W'(regs.thr));
    end
  end

endmodule

// File: rtl/irqmod_window.sv
module irqmod_window #(
  parameter int IN_W       = 18,
  parameter int UNIT_SHIFT = 8,
  parameter int CNT_W      = IN_W + UNIT_SHIFT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic [IN_W-1:0] delay,
  input  logic            tick,
  output logic            running
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             load;

  always_comb begin
    load  = arm && (delay != '0);
    cnt_d = cnt_q;
    run_d = run_q;
    if (load) begin
      cnt_d = CNT_W'(delay) << UNIT_SHIFT;
      run_d = 1'b1;
    end else if (run_q && tick) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign running = run_q;

  // R3: the caller only arms an idle timer
  p_arm_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> !run_q);
  // R3: each tick removes exactly one from a live count
  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && tick && !arm && cnt_q > CNT_W'(1) |=> run_q && cnt_q == $past(cnt_q) - CNT_W'(1));
  // R4: a zero delay never starts the timer
  p_zero_no_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arm && delay == '0 |=> !run_q);

endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irqmod_pkg::*;
#(
  parameter int CAUSE_W    = 16,
  parameter int TXDW_BIT   = 0,
  parameter int TXQE_BIT   = 1,
  parameter int RXT_BIT    = 7,
  parameter int ABS_SHIFT  = 2,
  parameter int UNIT_TICKS = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mit_enable,
  input  logic               ns_tick,
  input  logic [CAUSE_W-1:0] irq_cause,
  input  logic [CAUSE_W-1:0] irq_mask,
  input  logic               dly_wr,
  input  logic [1:0]         dly_addr,
  input  logic [DLY_W-1:0]   dly_wdata,
  output logic [DLY_W-1:0]   dly_rdata,
  input  logic               txd_strobe,
  input  logic               txd_dly_en,
  output logic               irq_line
);

  localparam int SEL_W      = DLY_W + ABS_SHIFT;
  localparam int UNIT_SHIFT = $clog2(UNIT_TICKS);

  logic             rst_n_s;
  dly_regs_t        regs;
  logic [CAUSE_W-1:0] pending;
  logic             pend_any;
  logic             level_q, level_d;
  logic             ide_q, ide_d;
  logic             running;
  logic             rise;
  logic             compute;
  logic [SEL_W-1:0] delay;

  irqmod_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  irqmod_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n_s),
    .wr    (dly_wr),
    .addr  (dly_addr),
    .wdata (dly_wdata),
    .rdata (dly_rdata),
    .regs  (regs)
  );

  irqmod_delay_sel #(
    .CAUSE_W   (CAUSE_W),
    .TXDW_BIT  (TXDW_BIT),
    .TXQE_BIT  (TXQE_BIT),
    .RXT_BIT   (RXT_BIT),
    .ABS_SHIFT (ABS_SHIFT),
    .OUT_W     (SEL_W)
  ) u_sel (
    .pending  (pending),
    .ide_flag (ide_q),
    .regs     (regs),
    .delay    (delay)
  );

  irqmod_window #(
    .IN_W       (SEL_W),
    .UNIT_SHIFT (UNIT_SHIFT)
  ) u_win (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .arm     (compute),
    .delay   (delay),
    .tick    (ns_tick),
    .running (running)
  );

  // edge tracking and flag next state
  always_comb begin
    pending  = irq_mask & irq_cause;
    pend_any = |pending;
    rise     = !level_q && pend_any;
    compute  = rise && !running && mit_enable;
    level_d  = (rise && running) ? 1'b0 : pend_any;
    ide_d    = (ide_q && !compute) || (txd_strobe && txd_dly_en);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      level_q <= 1'b0;
      ide_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      ide_q   <= ide_d;
    end
  end

  assign irq_line = level_q;

  // R3: a low line stays low while the window runs
  p_hold_low_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    running && !level_q |=> !irq_line);
  // R2: a rise is always backed by a pending cause
  p_rise_backed_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(irq_line) |-> $past(pend_any));
  // R9: disabled mitigation never starts a window
  p_no_arm_off_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !mit_enable && !running |=> !running);
  // R8: a computation consumes the delay-enable flag
  p_ide_consumed_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    compute && !(txd_strobe && txd_dly_en) |=> !ide_q);

endmodule

// File: tb/irq_moderator_tb.sv
module irq_moderator_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CW         = 16;
  localparam int WDOG       = 150000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mit_enable;
  logic          ns_tick;
  logic [CW-1:0] irq_cause;
  logic [CW-1:0] irq_mask;
  logic          dly_wr;
  logic [1:0]    dly_addr;
  logic [15:0]   dly_wdata;
  logic [15:0]   dly_rdata;
  logic          txd_strobe;
  logic          txd_dly_en;
  logic          irq_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_moderator u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mit_enable (mit_enable),
    .ns_tick    (ns_tick),
    .irq_cause  (irq_cause),
    .irq_mask   (irq_mask),
    .dly_wr     (dly_wr),
    .dly_addr   (dly_addr),
    .dly_wdata  (dly_wdata),
    .dly_rdata  (dly_rdata),
    .txd_strobe (txd_strobe),
    .txd_dly_en (txd_dly_en),
    .irq_line   (irq_line)
  );

  typedef struct {
    int    at;
    string tag;
  } rise_t;

  rise_t exp_q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_tag = "R2";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [CW-1:0] bitv(int i);
    return CW'(1) << i;
  endfunction

  task automatic wait_neg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rise(int at, string tag);
    rise_t r;
    r.at  = at;
    r.tag = tag;
    exp_q.push_back(r);
  endtask

  task automatic check_empty(string tag);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s missing rise: actual none, expected at cycle %0d", tag, exp_q[0].at);
      exp_q.delete();
    end
  endtask

  task automatic check_val(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic write_reg(logic [1:0] a, logic [15:0] v);
    @(negedge clk);
    dly_wr = 1'b1; dly_addr = a; dly_wdata = v;
    @(negedge clk);
    dly_wr = 1'b0;
  endtask

  task automatic read_check(logic [1:0] a, logic [15:0] v, string tag);
    @(negedge clk);
    dly_addr = a;
    #1;
    check_val(tag, 32'(dly_rdata), 32'(v));
  endtask

  task automatic set_regs(logic [15:0] g, logic [15:0] ra, logic [15:0] ta, logic [15:0] th);
    write_reg(2'd0, g);
    write_reg(2'd1, ra);
    write_reg(2'd2, ta);
    write_reg(2'd3, th);
  endtask

  task automatic strobe_ide();
    @(negedge clk);
    txd_strobe = 1'b1; txd_dly_en = 1'b1;
    @(negedge clk);
    txd_strobe = 1'b0; txd_dly_en = 1'b0;
  endtask

  // edge passes, drop, edge passes again with no hold-off
  task automatic pass_test(logic [CW-1:0] val, string tag);
    int t0;
    cur_tag = tag;
    @(negedge clk);
    t0 = cyc; irq_cause = val; expect_rise(t0 + 1, tag);
    wait_neg(3); irq_cause = '0;
    wait_neg(2); expect_rise(cyc + 1, tag); irq_cause = val;
    wait_neg(3); irq_cause = '0;
    wait_neg(4);
    check_val({tag, " R2 line low after drop"}, 32'(irq_line), 32'd0);
    check_empty(tag);
  endtask

  // first edge passes and arms n cycles; re-raise inside is held to the end
  task automatic window_test(logic [CW-1:0] val, int n, string tag);
    int t0;
    cur_tag = tag;
    @(negedge clk);
    t0 = cyc; irq_cause = val; expect_rise(t0 + 1, tag);
    wait_neg(3); irq_cause = '0;
    wait_neg(2); irq_cause = val; expect_rise(t0 + n + 2, tag);
    wait_neg(n + 10); irq_cause = '0;
    wait_neg(2200);
    check_empty(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(4);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // monitor: every observed rise is popped against the scoreboard
  initial begin
    logic prev;
    rise_t r;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (irq_line === 1'b1 && prev !== 1'b1) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL %s unexpected rise: actual cycle %0d, expected none", cur_tag, cyc);
        end else begin
          r = exp_q.pop_front();
          if (r.at != cyc) begin
            errors++;
            $display("FAIL %s rise: actual cycle %0d, expected cycle %0d", r.tag, cyc, r.at);
          end
        end
      end
      prev = irq_line;
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog: actual cycle %0d, expected finish before %0d", cyc, WDOG);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mit_enable = 1'b0; ns_tick = 1'b1;
    irq_cause = '0; irq_mask = '1;
    dly_wr = 1'b0; dly_addr = '0; dly_wdata = '0;
    txd_strobe = 1'b0; txd_dly_en = 1'b0;
    wait_neg(4);
    rst_n = 1'b1;
    wait_neg(4);

    // R11 / R10: reset state
    check_val("R11 line after reset", 32'(irq_line), 32'd0);
    for (int a = 0; a < 4; a++) read_check(2'(a), 16'h0, "R10 reset value");

    // R10: write and read back all four
    set_regs(16'hA5C3, 16'h0001, 16'hFFFF, 16'h1234);
    read_check(2'd0, 16'hA5C3, "R10 rx gate");
    read_check(2'd1, 16'h0001, "R10 rx abs");
    read_check(2'd2, 16'hFFFF, "R10 tx abs");
    read_check(2'd3, 16'h1234, "R10 throttle");

    // R9: mitigation off, throttle set, no hold-off
    set_regs(16'h0, 16'h0, 16'h0, 16'h0001);
    pass_test(bitv(2), "R9");

    // R4: on, all candidates zero
    mit_enable = 1'b1;
    write_reg(2'd3, 16'h0);
    pass_test(bitv(0), "R4");

    // R7 / R3: throttle only
    write_reg(2'd3, 16'h0001);
    window_test(bitv(2), 256, "R7");
    write_reg(2'd3, 16'h0002);
    window_test(bitv(0), 512, "R3");

    // R5: transmit candidate
    set_regs(16'h0, 16'h0, 16'h0001, 16'h0008);
    strobe_ide();
    window_test(bitv(0), 1024, "R5");
    window_test(bitv(0), 2048, "R5");
    strobe_ide();
    window_test(bitv(1), 1024, "R5");
    strobe_ide();
    window_test(bitv(2), 2048, "R5");
    window_test(bitv(0), 2048, "R8");

    // R6: receive candidate
    set_regs(16'h0005, 16'h0001, 16'h0, 16'h0008);
    window_test(bitv(7), 1024, "R6");
    write_reg(2'd0, 16'h0);
    window_test(bitv(7), 2048, "R6");
    write_reg(2'd0, 16'h0005);
    window_test(bitv(2), 2048, "R6");

    // R8: flag consumed by a zero-delay computation
    set_regs(16'h0, 16'h0, 16'h0001, 16'h0);
    strobe_ide();
    pass_test(bitv(2), "R8");
    pass_test(bitv(0), "R8");

    // R1: masked cause never raises the line
    cur_tag = "R1";
    irq_mask = ~bitv(2);
    @(negedge clk); irq_cause = bitv(2);
    wait_neg(10);
    check_val("R1 masked cause", 32'(irq_line), 32'd0);
    check_empty("R1");
    irq_cause = '0; irq_mask = '1;
    wait_neg(2);

    // R11: reset mid-window cancels it and clears the flag
    set_regs(16'h0, 16'h0, 16'h0001, 16'h0008);
    cur_tag = "R11";
    @(negedge clk); irq_cause = bitv(2); expect_rise(cyc + 1, "R11");
    wait_neg(5); irq_cause = '0;
    strobe_ide();
    do_reset();
    check_empty("R11");
    set_regs(16'h0, 16'h0, 16'h0001, 16'h0008);
    window_test(bitv(0), 2048, "R11");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule